// File: doc/BRIEF.md
# Multiprocessor System Control Registers

This block is a small register slave that gives boot firmware a handful of platform services on a multiprocessor system. An upstream bus fabric presents an already-reduced 6-bit byte offset, read and write strobes, a byte count and up to two bytes of write data. Firmware can stop the machine with an exit code, ask which processor it is running on, ask how many processors the platform has, and place a level on the interrupt input of any processor.

Interrupts are raised by one two-byte store that carries a line index and a level. Each line keeps the level it was given until that same line is written again, so the processors see level-sensitive requests, not pulses. The halt request stays set until reset, and the exit code shows the most recent halt store. Read data is 8 bits wide and comes from a register: it is valid in the cycle after the read strobe and zero in every other cycle.

Top module: `sysctl_regs`

## Requirements
- R1: A write strobe with offset 0 sets `halt_req` on the next clock edge, and `halt_req` stays set until reset.
- R2: `exit_code` shows bits [15:8] of the most recent write to offset 0, from the cycle after that write.
- R3: A read strobe with offset 4 puts `bus_req_id`, zero-extended to 8 bits, on `bus_rdata` in the following cycle.
- R4: A read strobe with offset 12 puts the configured processor count `CPU_CFG` on `bus_rdata` in the following cycle. When `CPU_CFG` is 0, the value is 1.
- R5: A write to offset 8 with `bus_size` of 2 or more takes the line index from `bus_wdata[15:8]` (the low-address byte) and the level from `bus_wdata[7:0]`. From the next cycle that level appears on `irq_level[8*index +: 8]`.
- R6: A write to offset 8 with `bus_size` of 0 or 1 drives level 0 onto the selected line.
- R7: An interrupt line changes only through a write to offset 8 that selects it. All other lines keep their levels.
- R8: An interrupt write whose line index is `NUM_CPU` or above changes no line.
- R9: `bus_rdata` is 0 in any cycle not directly after a read strobe, and 0 after a read of any offset other than 4 or 12.
- R10: Writes to any offset other than 0 and 8, including 1 to 3 and the read-only offsets 4 and 12, change neither `halt_req`, `exit_code` nor any interrupt line.
- R11: During and right after reset, `halt_req`, `exit_code`, `bus_rdata` and every interrupt line are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ofs | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Number of bytes in the store |
| bus_wdata | input | 16 | Write data; bits [15:8] are the low-address byte |
| bus_req_id | input | max(1, clog2(NUM_CPU)) | Index of the processor issuing the access |
| bus_rdata | output | 8 | Read data, registered |
| halt_req | output | 1 | Sticky halt request |
| exit_code | output | 8 | Exit status from the last halt store |
| irq_level | output | 8*NUM_CPU | Interrupt level per processor, line k in bits [8k+7:8k] |

## Verification
The bench uses four processors, so the requester ID has two bits. It builds two copies of the block that share stimulus: one with `CPU_CFG` of 0, which exercises the count fallback, and one with `CPU_CFG` of 3. With four lines, every line index and every requester ID can be swept, along with all 64 offsets for both reads and writes. Line indices from 4 to 255 cover the ignored range from the first index that is out of range to the largest byte value.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int          OFS_W     = 6;
   localparam int          BYTE_W    = 8;
   localparam logic [5:0]  OFS_HALT  = 6'd0;
   localparam logic [5:0]  OFS_REQID = 6'd4;
   localparam logic [5:0]  OFS_IRQ   = 6'd8;
   localparam logic [5:0]  OFS_NCPU  = 6'd12;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
(
   input  logic [OFS_W-1:0] ofs,
   input  logic             wr,
   input  logic             rd,
   output logic             wr_halt,
   output logic             wr_irq,
   output logic             rd_reqid,
   output logic             rd_ncpu
);
   always_comb begin
      wr_halt  = wr && (ofs == OFS_HALT);
      wr_irq   = wr && (ofs == OFS_IRQ);
      rd_reqid = rd && (ofs == OFS_REQID);
      rd_ncpu  = rd && (ofs == OFS_NCPU);
   end
endmodule

// File: rtl/sysctl_irq_bank.sv
module sysctl_irq_bank
   import sysctl_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_irq,
   input  logic [1:0]                size,
   input  logic [BYTE_W-1:0]         port_sel,
   input  logic [BYTE_W-1:0]         level_in,
   output logic [NUM_CPU*BYTE_W-1:0] lines
);
   logic [BYTE_W-1:0] new_level;

   // a one-byte store carries no level byte, so level 0 is driven
   always_comb new_level = (size >= 2'd2) ? level_in : '0;

   for (genvar g = 0; g < NUM_CPU; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n)
            lines[g*BYTE_W +: BYTE_W] <= '0;
         else if (wr_irq && (int'(port_sel) == g))
            lines[g*BYTE_W +: BYTE_W] <= new_level;
      end
   end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int CPU_CFG = 0,
   parameter int ID_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_reqid,
   input  logic              rd_ncpu,
   input  logic [ID_W-1:0]   req_id,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] count_byte;

   if (CPU_CFG == 0) begin : g_cnt_default
      assign count_byte = 8'd1;
   end else begin : g_cnt_cfg
      assign count_byte = 8'(CPU_CFG);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_reqid)
         rdata <= 8'(req_id);
      else if (rd_ncpu)
         rdata <= count_byte;
      else
         rdata <= '0;
   end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int NUM_CPU = 4,
   parameter int CPU_CFG = 0,
   localparam int ID_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [OFS_W-1:0]          bus_ofs,
   input  logic                      bus_wr,
   input  logic                      bus_rd,
   input  logic [1:0]                bus_size,
   input  logic [15:0]               bus_wdata,
   input  logic [ID_W-1:0]           bus_req_id,
   output logic [BYTE_W-1:0]         bus_rdata,
   output logic                      halt_req,
   output logic [BYTE_W-1:0]         exit_code,
   output logic [NUM_CPU*BYTE_W-1:0] irq_level
);
   if (NUM_CPU < 1 || NUM_CPU > 256) begin : g_bad_num_cpu
      $error("sysctl_regs: NUM_CPU must lie in 1..256");
   end
   if (CPU_CFG < 0 || CPU_CFG > 255) begin : g_bad_cpu_cfg
      $error("sysctl_regs: CPU_CFG must lie in 0..255");
   end

   logic wr_halt, wr_irq, rd_reqid, rd_ncpu;

   sysctl_decode u_dec (
      .ofs      (bus_ofs),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .wr_halt  (wr_halt),
      .wr_irq   (wr_irq),
      .rd_reqid (rd_reqid),
      .rd_ncpu  (rd_ncpu)
   );

   sysctl_irq_bank #(.NUM_CPU(NUM_CPU)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_irq   (wr_irq),
      .size     (bus_size),
      .port_sel (bus_wdata[15:8]),
      .level_in (bus_wdata[7:0]),
      .lines    (irq_level)
   );

   sysctl_rdmux #(.CPU_CFG(CPU_CFG), .ID_W(ID_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_reqid (rd_reqid),
      .rd_ncpu  (rd_ncpu),
      .req_id   (bus_req_id),
      .rdata    (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_req  <= 1'b0;
         exit_code <= '0;
      end else if (wr_halt) begin
         halt_req  <= 1'b1;
         exit_code <= bus_wdata[15:8];
      end
   end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
   parameter int NUM_CPU = 4,
   parameter int ID_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [5:0]           bus_ofs,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [15:0]          bus_wdata,
   input logic [7:0]           bus_rdata,
   input logic                 halt_req,
   input logic [7:0]           exit_code,
   input logic [NUM_CPU*8-1:0] irq_level
);
   p_halt_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |=> halt_req);

   p_halt_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halt_req) |-> $past(bus_wr && bus_ofs == 6'd0));

   p_code_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(exit_code) |-> $past(bus_wr && bus_ofs == 6'd0));

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq_level) |-> $past(bus_wr && bus_ofs == 6'd8));

   p_oob_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_ofs == 6'd8 && int'(bus_wdata[15:8]) >= NUM_CPU)
      |=> $stable(irq_level));

   p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 8'd0));
endmodule

bind sysctl_regs sysctl_regs_chk #(.NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_ofs   (bus_ofs),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .halt_req  (halt_req),
   .exit_code (exit_code),
   .irq_level (irq_level)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    bus_ofs = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [1:0]    bus_size = '0;
   logic [15:0]   bus_wdata = '0;
   logic [1:0]    bus_req_id = '0;
   logic [7:0]    rdata_a, rdata_b, code_a, code_b;
   logic          halt_a, halt_b;
   logic [N*8-1:0] irq_a, irq_b;
   logic [N*8-1:0] exp_irq = '0;
   int            total = 0;
   int            fails = 0;
   bit            done = 1'b0;

   always #5 clk = ~clk;

   sysctl_regs #(.NUM_CPU(N), .CPU_CFG(0)) uut (
      .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_req_id(bus_req_id),
      .bus_rdata(rdata_a), .halt_req(halt_a), .exit_code(code_a), .irq_level(irq_a));

   sysctl_regs #(.NUM_CPU(N), .CPU_CFG(3)) uut_cfg (
      .clk(clk), .rst_n(rst_n), .bus_ofs(bus_ofs), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_req_id(bus_req_id),
      .bus_rdata(rdata_b), .halt_req(halt_b), .exit_code(code_b), .irq_level(irq_b));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [5:0] ofs, input logic [1:0] sz, input logic [15:0] d);
      @(negedge clk);
      bus_ofs = ofs; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [5:0] ofs, input logic [1:0] id);
      @(negedge clk);
      bus_ofs = ofs; bus_req_id = id; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic chk_irq(input string req);
      chk(req, irq_a, exp_irq);
      chk(req, irq_b, exp_irq);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 halt", {31'b0, halt_a}, 0);
      chk("R11 code", {24'b0, code_a}, 0);
      chk("R11 rdata", {24'b0, rdata_a}, 0);
      chk_irq("R11 irq");
      rst_n = 1'b1;
      @(negedge clk);
      chk_irq("R11 irq after release");

      // R3: requester ID sweep
      for (int id = 0; id < N; id++) begin
         do_rd(6'd4, 2'(id));
         chk("R3 reqid", {24'b0, rdata_a}, id);
         chk("R3 reqid cfg", {24'b0, rdata_b}, id);
      end

      // R4: processor count, default and configured
      do_rd(6'd12, 2'd2);
      chk("R4 count default", {24'b0, rdata_a}, 1);
      chk("R4 count cfg", {24'b0, rdata_b}, 3);

      // R9: every other offset reads zero, idle cycle reads zero
      for (int o = 0; o < 64; o++) begin
         if (o != 4 && o != 12) begin
            do_rd(6'(o), 2'd3);
            chk("R9 unmapped read", {24'b0, rdata_a}, 0);
         end
      end
      do_rd(6'd12, 2'd0);
      @(negedge clk);
      chk("R9 idle rdata", {24'b0, rdata_b}, 0);

      // R10: writes outside offsets 0 and 8 have no effect
      for (int o = 1; o < 64; o++) begin
         if (o != 8) do_wr(6'(o), 2'd2, 16'h0155);
      end
      chk("R10 halt", {31'b0, halt_a}, 0);
      chk("R10 code", {24'b0, code_a}, 0);
      chk_irq("R10 irq");

      // R5/R7: two-byte store on each line, others keep their levels
      for (int p = 0; p < N; p++) begin
         logic [7:0] lv = 8'(16 * p + 7);
         do_wr(6'd8, 2'd2, {8'(p), lv});
         exp_irq[p*8 +: 8] = lv;
         chk_irq("R5 R7 set line");
      end
      do_wr(6'd8, 2'd3, {8'd1, 8'hC3});
      exp_irq[8 +: 8] = 8'hC3;
      chk_irq("R5 rewrite line 1");

      // R6: single-byte store clears the selected line
      do_wr(6'd8, 2'd1, {8'd2, 8'hFF});
      exp_irq[16 +: 8] = 8'h00;
      chk_irq("R6 single byte");
      do_wr(6'd8, 2'd0, {8'd3, 8'hFF});
      exp_irq[24 +: 8] = 8'h00;
      chk_irq("R6 zero size");

      // R8: indices at or above N are ignored
      do_wr(6'd8, 2'd2, {8'd4, 8'h99});
      chk_irq("R8 index 4");
      do_wr(6'd8, 2'd2, {8'd200, 8'h99});
      chk_irq("R8 index 200");
      do_wr(6'd8, 2'd2, {8'd255, 8'h99});
      chk_irq("R8 index 255");

      // R1/R2: halt and exit code
      do_wr(6'd0, 2'd1, 16'h2A00);
      chk("R1 halt set", {31'b0, halt_a}, 1);
      chk("R2 code", {24'b0, code_a}, 32'h2A);
      do_wr(6'd0, 2'd2, 16'h77EE);
      chk("R2 code update", {24'b0, code_b}, 32'h77);
      repeat (5) @(negedge clk);
      chk("R1 halt held", {31'b0, halt_b}, 1);
      chk_irq("R7 irq held");

      finish_run();
   end
endmodule